// File: doc/BRIEF.md
# Bus Time-out and Watchdog Monitor

This block supervises a processor bus with two independent timers. The first timer counts clock cycles while a bus cycle is waiting for its ready response. If ready does not arrive within a selectable limit of 64 or 128 cycles, it records a bus fault. The second timer is a software watchdog. It is loaded from a 16-bit setup register and counts down on an externally supplied tick, either a 1 MHz tick or a 1 kHz tick. Software must service it with a reload strobe before the count runs out.

Each timer sets its own sticky status flag and raises a one-cycle fault pulse when it fires. The flags stay set until the status read strobe clears them. The two tick inputs come from a divider outside the block. The block only selects between them.

Top module: `bus_wdt_monitor`

## Requirements
- R1: After reset both status flags are 0, both fault pulses are 0, the watchdog setup register holds 0000 and the watchdog count is 0.
- R2: While the bus time-out is enabled and a cycle is pending (bus_active=1, bus_ready=0), the bus flag and a one-cycle bus_fault pulse appear at the clock edge that ends the limit-th consecutive pending cycle. The limit is 64 cycles when bto_long_sel=0 and 128 cycles when bto_long_sel=1.
- R3: A cycle that completes with bus_ready=1, or that ends with bus_active=0, before the limit is reached clears the bus counter. The next pending cycle then counts again from zero, and no fault occurs.
- R4: With bto_en=0 the bus timer never reports a fault, however long a cycle stays pending.
- R5: A wdt_kick strobe loads the watchdog count from the setup register at the next edge, and the kick takes priority over a tick in the same cycle. A write with wdt_setup_we updates the setup register at the next edge.
- R6: With wdt_en=1 the count decrements by one on each cycle in which the selected tick is high. tick_1mhz is selected when wdt_slow_sel=0 and tick_1khz when wdt_slow_sel=1. The unselected tick has no effect.
- R7: When a decrement takes the count from 1 to 0, the watchdog flag sets and wdt_fault pulses for exactly one cycle. The count then stays at 0, with no further pulse, until the next kick.
- R8: With wdt_en=0 the watchdog count holds its value on ticks.
- R9: A one-cycle status_rd clears both flags at the next edge. A flag whose timer fires in the same cycle as status_rd stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bto_en | input | 1 | Bus time-out enable |
| bto_long_sel | input | 1 | Limit select: 1 = 128 cycles, 0 = 64 cycles |
| bus_active | input | 1 | A bus cycle is in progress |
| bus_ready | input | 1 | Ready response for the current cycle |
| wdt_en | input | 1 | Watchdog enable |
| wdt_slow_sel | input | 1 | Tick select: 1 = 1 kHz tick, 0 = 1 MHz tick |
| tick_1khz | input | 1 | One-clock pulse at 1 kHz |
| tick_1mhz | input | 1 | One-clock pulse at 1 MHz |
| wdt_setup_we | input | 1 | Write strobe for the setup register |
| wdt_setup_d | input | 16 | Setup count to write |
| wdt_kick | input | 1 | Software service strobe, reloads the count |
| status_rd | input | 1 | Status read strobe, clears both flags |
| wdt_count | output | 16 | Current watchdog count |
| bus_fault | output | 1 | One-cycle pulse on bus time-out |
| wdt_fault | output | 1 | One-cycle pulse on watchdog terminal count |
| flag_bto | output | 1 | Sticky bus time-out flag |
| flag_wdt | output | 1 | Sticky watchdog terminal-count flag |

## Verification
The assertions assume that each tick input is a single-clock pulse and that status_rd and wdt_kick are single-cycle strobes. They also assume that the control selects are stable while a timer is running. The bench drives every strobe for exactly one cycle, at the falling edge. It changes enables and selects only while no bus cycle is pending and the watchdog is idle or freshly kicked. It never lets the unselected tick coincide with a check that depends on it, except in the test meant to show that tick is ignored.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

  // Bus time-out limit in cycles, chosen by the select bit.
  function automatic int unsigned bto_limit(input logic long_sel,
                                            input int unsigned short_lim,
                                            input int unsigned long_lim);
    return long_sel ? long_lim : short_lim;
  endfunction

  // A pending cycle has waited long enough once this cycle ends the limit-th.
  function automatic logic bto_expired(input int unsigned waited,
                                       input int unsigned limit);
    return (waited + 1) >= limit;
  endfunction

endpackage

// File: rtl/bwm_bus_timer.sv
module bwm_bus_timer #(
  parameter int unsigned SHORT_LIM = 64,
  parameter int unsigned LONG_LIM  = 128,
  localparam int unsigned CW = $clog2(LONG_LIM + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          long_sel,
  input  logic          active,
  input  logic          ready,
  output logic          hit,
  output logic          fault,
  output logic [CW-1:0] waited
);
  import bwm_pkg::*;

  logic        pending;
  logic        fired;
  int unsigned limit;

  always_comb begin
    pending = en & active & ~ready;
    limit   = bto_limit(long_sel, SHORT_LIM, LONG_LIM);
    hit     = pending & ~fired & bto_expired(int'(waited), limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waited <= '0;
      fired  <= 1'b0;
      fault  <= 1'b0;
    end else begin
      fault <= hit;
      if (!pending) begin
        waited <= '0;
        fired  <= 1'b0;
      end else begin
        if (int'(waited) < LONG_LIM) waited <= waited + 1'b1;
        if (hit) fired <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/bwm_watchdog.sv
module bwm_watchdog #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         slow_sel,
  input  logic         tick_slow,
  input  logic         tick_fast,
  input  logic         kick,
  input  logic         setup_we,
  input  logic [W-1:0] setup_d,
  output logic [W-1:0] count,
  output logic [W-1:0] setup_q,
  output logic         step,
  output logic         hit,
  output logic         fault
);

  function automatic logic [W-1:0] next_count(input logic [W-1:0] cur,
                                              input logic [W-1:0] load,
                                              input logic         do_load,
                                              input logic         do_step);
    if (do_load)                  return load;
    if (do_step && cur != '0)     return cur - 1'b1;
    return cur;
  endfunction

  always_comb begin
    step = en & (slow_sel ? tick_slow : tick_fast);
    hit  = ~kick & step & (count == W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      setup_q <= '0;
      fault   <= 1'b0;
    end else begin
      if (setup_we) setup_q <= setup_d;
      count <= next_count(count, setup_q, kick, step);
      fault <= hit;
    end
  end

endmodule

// File: rtl/bwm_status.sv
module bwm_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_bto,
  input  logic set_wdt,
  input  logic clr,
  output logic flag_bto,
  output logic flag_wdt
);

  function automatic logic sticky(input logic cur, input logic set, input logic c);
    return set | (cur & ~c);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_bto <= 1'b0;
      flag_wdt <= 1'b0;
    end else begin
      flag_bto <= sticky(flag_bto, set_bto, clr);
      flag_wdt <= sticky(flag_wdt, set_wdt, clr);
    end
  end

endmodule

// File: rtl/bus_wdt_monitor.sv
module bus_wdt_monitor #(
  parameter int unsigned WDT_W     = 16,
  parameter int unsigned BTO_SHORT = 64,
  parameter int unsigned BTO_LONG  = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bto_en,
  input  logic             bto_long_sel,
  input  logic             bus_active,
  input  logic             bus_ready,
  input  logic             wdt_en,
  input  logic             wdt_slow_sel,
  input  logic             tick_1khz,
  input  logic             tick_1mhz,
  input  logic             wdt_setup_we,
  input  logic [WDT_W-1:0] wdt_setup_d,
  input  logic             wdt_kick,
  input  logic             status_rd,
  output logic [WDT_W-1:0] wdt_count,
  output logic             bus_fault,
  output logic             wdt_fault,
  output logic             flag_bto,
  output logic             flag_wdt
);
  localparam int unsigned BCW = $clog2(BTO_LONG + 1);

  logic             bto_hit;
  logic [BCW-1:0]   bto_waited;
  logic             wdt_hit;
  logic             wdt_step;
  logic [WDT_W-1:0] wdt_setup_q;

  bwm_bus_timer #(.SHORT_LIM(BTO_SHORT), .LONG_LIM(BTO_LONG)) u_bus (
    .clk(clk), .rst_n(rst_n), .en(bto_en), .long_sel(bto_long_sel),
    .active(bus_active), .ready(bus_ready),
    .hit(bto_hit), .fault(bus_fault), .waited(bto_waited)
  );

  bwm_watchdog #(.W(WDT_W)) u_wdt (
    .clk(clk), .rst_n(rst_n), .en(wdt_en), .slow_sel(wdt_slow_sel),
    .tick_slow(tick_1khz), .tick_fast(tick_1mhz), .kick(wdt_kick),
    .setup_we(wdt_setup_we), .setup_d(wdt_setup_d),
    .count(wdt_count), .setup_q(wdt_setup_q), .step(wdt_step),
    .hit(wdt_hit), .fault(wdt_fault)
  );

  bwm_status u_stat (
    .clk(clk), .rst_n(rst_n), .set_bto(bto_hit), .set_wdt(wdt_hit),
    .clr(status_rd), .flag_bto(flag_bto), .flag_wdt(flag_wdt)
  );

endmodule

// File: rtl/bwm_checker.sv
module bwm_checker #(
  parameter int unsigned WDT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bto_en,
  input logic             wdt_en,
  input logic             wdt_kick,
  input logic             status_rd,
  input logic             bto_hit,
  input logic             wdt_hit,
  input logic             bus_fault,
  input logic             wdt_fault,
  input logic             flag_bto,
  input logic             flag_wdt,
  input logic [WDT_W-1:0] wdt_count,
  input logic [WDT_W-1:0] wdt_setup_q
);

  // R2
  bto_flag_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_fault |-> flag_bto);

  // R4
  bto_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bto_en |=> !bus_fault);

  // R5
  wdt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_kick |=> wdt_count == $past(wdt_setup_q));

  // R7
  wdt_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_fault |=> !wdt_fault);

  // R7
  wdt_fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_fault |-> (wdt_count == '0 && flag_wdt));

  // R8
  wdt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdt_en && !wdt_kick) |=> $stable(wdt_count));

  // R9
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !bto_hit && !wdt_hit) |=> (!flag_bto && !flag_wdt));

endmodule

bind bus_wdt_monitor bwm_checker #(.WDT_W(WDT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bto_en(bto_en), .wdt_en(wdt_en),
  .wdt_kick(wdt_kick), .status_rd(status_rd), .bto_hit(bto_hit),
  .wdt_hit(wdt_hit), .bus_fault(bus_fault), .wdt_fault(wdt_fault),
  .flag_bto(flag_bto), .flag_wdt(flag_wdt), .wdt_count(wdt_count),
  .wdt_setup_q(wdt_setup_q)
);

// File: tb/bus_wdt_monitor_tb.sv
module bus_wdt_monitor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bto_en = 0, bto_long_sel = 0, bus_active = 0, bus_ready = 0;
  logic        wdt_en = 0, wdt_slow_sel = 0, tick_1khz = 0, tick_1mhz = 0;
  logic        wdt_setup_we = 0, wdt_kick = 0, status_rd = 0;
  logic [15:0] wdt_setup_d = '0;
  logic [15:0] wdt_count;
  logic        bus_fault, wdt_fault, flag_bto, flag_wdt;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  bus_wdt_monitor u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_status();
    status_rd = 1; cyc(1); status_rd = 0;
  endtask

  task automatic fast_tick();
    tick_1mhz = 1; cyc(1); tick_1mhz = 0;
  endtask

  task automatic t_reset();
    chk("R1 flag_bto", flag_bto, 0);
    chk("R1 flag_wdt", flag_wdt, 0);
    chk("R1 faults", {bus_fault, wdt_fault}, 0);
    chk("R1 count", wdt_count, 0);
    wdt_kick = 1; cyc(1); wdt_kick = 0;
    chk("R1 setup reset value", wdt_count, 0);
  endtask

  task automatic t_bus_limit(input logic long_sel);
    int lim = long_sel ? 128 : 64;
    bto_en = 1; bto_long_sel = long_sel;
    bus_active = 1; bus_ready = 0;
    cyc(lim - 1);
    chk("R2 no flag before limit", flag_bto, 0);
    cyc(1);
    chk("R2 flag at limit", flag_bto, 1);
    chk("R2 fault pulse", bus_fault, 1);
    cyc(1);
    chk("R2 pulse ends", bus_fault, 0);
    bus_active = 0; cyc(1);
    clear_status();
    chk("R9 cleared by read", flag_bto, 0);
  endtask

  task automatic t_bus_ready();
    bto_en = 1; bto_long_sel = 0;
    bus_active = 1; bus_ready = 0; cyc(63);
    bus_ready = 1; cyc(1);
    bus_ready = 0; cyc(63);
    chk("R3 ready restarts count", flag_bto, 0);
    bus_active = 0; cyc(1);
    bus_active = 1; cyc(63);
    chk("R3 idle restarts count", flag_bto, 0);
    bus_active = 0; cyc(1);
    chk("R3 no fault", flag_bto, 0);
  endtask

  task automatic t_bus_disabled();
    bto_en = 0; bus_active = 1; bus_ready = 0; cyc(200);
    chk("R4 disabled no flag", flag_bto, 0);
    bus_active = 0; cyc(1);
  endtask

  task automatic t_wdt_run();
    wdt_setup_d = 16'd5; wdt_setup_we = 1; cyc(1); wdt_setup_we = 0;
    wdt_kick = 1; cyc(1); wdt_kick = 0;
    chk("R5 load from setup", wdt_count, 5);
    wdt_en = 1; wdt_slow_sel = 0;
    fast_tick(); cyc(2);
    chk("R6 one decrement", wdt_count, 4);
    tick_1khz = 1; cyc(1); tick_1khz = 0;
    chk("R6 unselected tick ignored", wdt_count, 4);
    repeat (3) fast_tick();
    chk("R6 at one", wdt_count, 1);
    chk("R7 no flag yet", flag_wdt, 0);
    fast_tick();
    chk("R7 reaches zero", wdt_count, 0);
    chk("R7 fault pulse", wdt_fault, 1);
    chk("R7 flag set", flag_wdt, 1);
    fast_tick();
    chk("R7 single pulse", wdt_fault, 0);
    chk("R7 stays zero", wdt_count, 0);
    clear_status();
    chk("R9 wdt cleared", flag_wdt, 0);
  endtask

  task automatic t_wdt_slow_kick();
    wdt_setup_d = 16'd3; wdt_setup_we = 1; cyc(1); wdt_setup_we = 0;
    wdt_kick = 1; cyc(1); wdt_kick = 0;
    wdt_slow_sel = 1;
    fast_tick();
    chk("R6 fast ignored in slow mode", wdt_count, 3);
    tick_1khz = 1; cyc(1); tick_1khz = 0;
    chk("R6 slow tick counts", wdt_count, 2);
    wdt_kick = 1; tick_1khz = 1; cyc(1); wdt_kick = 0; tick_1khz = 0;
    chk("R5 kick beats tick", wdt_count, 3);
    wdt_en = 0;
    tick_1khz = 1; cyc(1); tick_1khz = 0;
    chk("R8 disabled holds", wdt_count, 3);
    wdt_en = 1;
    tick_1khz = 1; cyc(1); tick_1khz = 0;
    tick_1khz = 1; cyc(1); tick_1khz = 0;
    chk("R6 count one", wdt_count, 1);
    tick_1khz = 1; status_rd = 1; cyc(1); tick_1khz = 0; status_rd = 0;
    chk("R9 set wins over read", flag_wdt, 1);
    clear_status();
    chk("R9 later read clears", flag_wdt, 0);
    wdt_en = 0; wdt_slow_sel = 0;
  endtask

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    t_reset();
    t_bus_limit(0);
    t_bus_limit(1);
    t_bus_ready();
    t_bus_disabled();
    t_wdt_run();
    t_wdt_slow_kick();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule